// File: doc/BRIEF.md
# Multichannel DAC Parallel Register Port

This block is the parallel write side of a forty-channel converter register bank. A host drives a 14-bit data word, a 6-bit channel number and a 2-bit register-kind code. It then ends a strobe pulse with a rising edge while its select line is low. The block turns that rising edge into a single write. The write lands in the gain, offset or data storage of the chosen channel, or in a special function register.

Each channel keeps two data words, bank A and bank B. When the toggle enable held in special function register 0 is clear, every data write goes to bank A. When that enable is set, a bank-select input steers each data write to A or B. All stored values are presented continuously as flat buses for the downstream arithmetic and output logic. The register for channel c, field width 14, sits at bits `[c*14 +: 14]`.

The strobe and select inputs are sampled on the block clock. A write is recognised in the cycle where the sampled strobe is high after having been low. The addressed register takes its new value at that same clock edge.

Top module: `dacp_regif`

## Requirements
- R1: After reset every gain register holds 0x3FFF, every offset register holds 0x2000, both data banks of every channel hold 0x0000, and the toggle enable is 0.
- R2: A write is performed only on a rising edge of `wstb` that is sampled while `sel_n` is low. A pulse with `sel_n` high leaves every register unchanged. The written register shows the new value after the clock edge at which the rising edge is first sampled.
- R3: Holding `wstb` high writes once only. Changes on `din`, `chan_addr` or `reg_kind` while the strobe stays high have no effect.
- R4: With the toggle enable at 0, a write with `reg_kind` = 2'b11 stores `din` in bank A of the addressed channel whatever `bank_b` is, and bank B stays unchanged.
- R5: With the toggle enable at 1, a write with `reg_kind` = 2'b11 stores `din` in bank B when `bank_b` is 1 and in bank A when `bank_b` is 0.
- R6: A write with `reg_kind` = 2'b01 stores `din` in the gain register of the addressed channel. A write with `reg_kind` = 2'b10 stores it in the offset register.
- R7: A write with `reg_kind` = 2'b00 and `chan_addr` = 0 sets the toggle enable to `din[0]`. A write with `reg_kind` = 2'b00 and any other address changes nothing, and no write of kind 2'b00 touches a channel register.
- R8: A gain, offset or data write with `chan_addr` of 40 or more changes no register.
- R9: A qualified write changes at most one register in the whole bank. Channels 0 and 39 are as reachable as any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select, level sensitive |
| wstb | input | 1 | Write strobe; its rising edge launches a write |
| chan_addr | input | 6 | Channel number, or special function address for kind 2'b00 |
| reg_kind | input | 2 | 00 special function, 01 gain, 10 offset, 11 data |
| bank_b | input | 1 | Data bank steering in toggle mode (1 = bank B) |
| din | input | 14 | Write data, bit 13 most significant |
| toggle_en | output | 1 | Toggle-mode enable from special function register 0 |
| gain_flat | output | 560 | Gain registers, channel c at [c*14 +: 14] |
| offset_flat | output | 560 | Offset registers, channel c at [c*14 +: 14] |
| data_a_flat | output | 560 | Bank A data registers, channel c at [c*14 +: 14] |
| data_b_flat | output | 560 | Bank B data registers, channel c at [c*14 +: 14] |

## Verification
Writes are issued to each register kind at interior channels and at the end channels 0 and 39. After every write, a sweep over the whole bank separates a correct single-register update from a mis-decoded address or a broadcast. Data writes are repeated with the toggle enable off and on, and with both bank-select values, which separates the A-only behaviour from the steered behaviour. Pulses with select high, addresses at 40 and 63, special function addresses other than zero, and a strobe held high while the other inputs change each show that a qualification step is honoured rather than bypassed.

// File: rtl/dacp_pkg.sv
package dacp_pkg;

  localparam int DACP_CHANNELS = 40;
  localparam int DACP_DATA_W   = 14;
  localparam int DACP_ADDR_W   = 6;

  typedef enum logic [1:0] {
    KIND_SFR  = 2'b00,
    KIND_GAIN = 2'b01,
    KIND_OFS  = 2'b10,
    KIND_DATA = 2'b11
  } reg_kind_e;

  // Special function address holding the toggle-mode enable.
  localparam int SFR_TOGGLE_ADDR = 0;

  // True when an address names an existing channel.
  function automatic bit chan_in_range(input int unsigned addr, input int unsigned n_ch);
    return addr < n_ch;
  endfunction

  // Midscale code of a w-bit word: only the top bit set.
  function automatic int unsigned midscale_code(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // Full-scale code of a w-bit word: every bit set.
  function automatic int unsigned fullscale_code(input int unsigned w);
    return (32'd1 << w) - 1;
  endfunction

endpackage

// File: rtl/dacp_strobe.sv
module dacp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wstb,
  input  logic sel_n,
  output logic fire
);

  logic wstb_q;

  // Idle level of the strobe is high, so reset to high to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wstb_q <= 1'b1;
    else        wstb_q <= wstb;
  end

  assign fire = wstb && !wstb_q && !sel_n;

endmodule

// File: rtl/dacp_decode.sv
module dacp_decode
  import dacp_pkg::*;
#(
  parameter int CH_N   = DACP_CHANNELS,
  parameter int ADDR_W = DACP_ADDR_W
) (
  input  logic              fire,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic [1:0]        reg_kind,
  input  logic              bank_b,
  input  logic              toggle_en,
  output logic [CH_N-1:0]   chan_hit,
  output logic [CH_N-1:0]   gain_we,
  output logic [CH_N-1:0]   ofs_we,
  output logic [CH_N-1:0]   a_we,
  output logic [CH_N-1:0]   b_we,
  output logic              tog_we
);

  reg_kind_e kind;
  logic      to_b;

  assign kind = reg_kind_e'(reg_kind);
  assign to_b = toggle_en && bank_b;

  always_comb begin
    tog_we = fire && (kind == KIND_SFR) &&
             (int'(chan_addr) == SFR_TOGGLE_ADDR);
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    assign chan_hit[i] = fire && (kind != KIND_SFR) &&
                         (int'(chan_addr) == i);
    assign gain_we[i]  = chan_hit[i] && (kind == KIND_GAIN);
    assign ofs_we[i]   = chan_hit[i] && (kind == KIND_OFS);
    assign a_we[i]     = chan_hit[i] && (kind == KIND_DATA) && !to_b;
    assign b_we[i]     = chan_hit[i] && (kind == KIND_DATA) &&  to_b;
  end

endmodule

// File: rtl/dacp_chan.sv
module dacp_chan
  import dacp_pkg::*;
#(
  parameter int DW = DACP_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          gain_we,
  input  logic          ofs_we,
  input  logic          a_we,
  input  logic          b_we,
  output logic [DW-1:0] gain_q,
  output logic [DW-1:0] ofs_q,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q
);

  localparam logic [DW-1:0] GAIN_RST = DW'(fullscale_code(DW));
  localparam logic [DW-1:0] OFS_RST  = DW'(midscale_code(DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_RST;
      ofs_q  <= OFS_RST;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      if (gain_we) gain_q <= din;
      if (ofs_we)  ofs_q  <= din;
      if (a_we)    a_q    <= din;
      if (b_we)    b_q    <= din;
    end
  end

endmodule

// File: rtl/dacp_regif.sv
module dacp_regif
  import dacp_pkg::*;
#(
  parameter int CH_N   = DACP_CHANNELS,
  parameter int DW     = DACP_DATA_W,
  parameter int ADDR_W = DACP_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic               wstb,
  input  logic [ADDR_W-1:0]  chan_addr,
  input  logic [1:0]         reg_kind,
  input  logic               bank_b,
  input  logic [DW-1:0]      din,
  output logic               toggle_en,
  output logic [CH_N*DW-1:0] gain_flat,
  output logic [CH_N*DW-1:0] offset_flat,
  output logic [CH_N*DW-1:0] data_a_flat,
  output logic [CH_N*DW-1:0] data_b_flat
);

  // Named internal events, observed by the bound checker.
  logic            wr_fire;
  logic [CH_N-1:0] chan_hit;
  logic [CH_N-1:0] gain_we;
  logic [CH_N-1:0] ofs_we;
  logic [CH_N-1:0] a_we;
  logic [CH_N-1:0] b_we;
  logic            tog_we;

  dacp_strobe u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .wstb  (wstb),
    .sel_n (sel_n),
    .fire  (wr_fire)
  );

  dacp_decode #(
    .CH_N   (CH_N),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .fire      (wr_fire),
    .chan_addr (chan_addr),
    .reg_kind  (reg_kind),
    .bank_b    (bank_b),
    .toggle_en (toggle_en),
    .chan_hit  (chan_hit),
    .gain_we   (gain_we),
    .ofs_we    (ofs_we),
    .a_we      (a_we),
    .b_we      (b_we),
    .tog_we    (tog_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      toggle_en <= 1'b0;
    else if (tog_we) toggle_en <= din[0];
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    dacp_chan #(
      .DW (DW)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .gain_we (gain_we[c]),
      .ofs_we  (ofs_we[c]),
      .a_we    (a_we[c]),
      .b_we    (b_we[c]),
      .gain_q  (gain_flat[c*DW +: DW]),
      .ofs_q   (offset_flat[c*DW +: DW]),
      .a_q     (data_a_flat[c*DW +: DW]),
      .b_q     (data_b_flat[c*DW +: DW])
    );
  end

endmodule

// File: rtl/dacp_regif_chk.sv
module dacp_regif_chk #(
  parameter int CH_N   = 40,
  parameter int DW     = 14,
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_fire,
  input logic [CH_N-1:0]    chan_hit,
  input logic [ADDR_W-1:0]  chan_addr,
  input logic [1:0]         reg_kind,
  input logic               toggle_en,
  input logic [CH_N*DW-1:0] gain_flat,
  input logic [CH_N*DW-1:0] offset_flat,
  input logic [CH_N*DW-1:0] data_a_flat,
  input logic [CH_N*DW-1:0] data_b_flat
);

  // R9: at most one channel selected by any write
  assert_single_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_hit));

  // R2: no qualified write, no change anywhere
  assert_quiet_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(gain_flat) && $stable(offset_flat) &&
                  $stable(data_a_flat) && $stable(data_b_flat) && $stable(toggle_en)));

  // R3: a held strobe gives one write event only
  assert_one_event_per_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  // R8: out-of-range channel writes leave the bank alone
  assert_oob_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && reg_kind != 2'b00 && int'(chan_addr) >= CH_N) |=>
      ($stable(gain_flat) && $stable(offset_flat) &&
       $stable(data_a_flat) && $stable(data_b_flat)));

  // R4: normal mode data writes never reach bank B
  assert_normal_mode_bank_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && reg_kind == 2'b11 && !toggle_en) |=> $stable(data_b_flat));

  // R7: special function writes leave channel storage alone
  assert_sfr_spares_channels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && reg_kind == 2'b00) |=>
      ($stable(gain_flat) && $stable(offset_flat) &&
       $stable(data_a_flat) && $stable(data_b_flat)));

endmodule

bind dacp_regif dacp_regif_chk #(
  .CH_N   (CH_N),
  .DW     (DW),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_fire     (wr_fire),
  .chan_hit    (chan_hit),
  .chan_addr   (chan_addr),
  .reg_kind    (reg_kind),
  .toggle_en   (toggle_en),
  .gain_flat   (gain_flat),
  .offset_flat (offset_flat),
  .data_a_flat (data_a_flat),
  .data_b_flat (data_b_flat)
);

// File: tb/dacp_regif_bench.sv
`timescale 1ns/1ps
module dacp_regif_bench;

  localparam int NCH = 40;
  localparam int W   = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sel_n = 1'b1;
  logic           wstb = 1'b1;
  logic [5:0]     chan_addr = '0;
  logic [1:0]     reg_kind = '0;
  logic           bank_b = 1'b0;
  logic [W-1:0]   din = '0;
  logic           toggle_en;
  logic [NCH*W-1:0] gain_flat, offset_flat, data_a_flat, data_b_flat;

  always #4 clk = ~clk;

  dacp_regif u_dacp_regif (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb(wstb),
    .chan_addr(chan_addr), .reg_kind(reg_kind), .bank_b(bank_b), .din(din),
    .toggle_en(toggle_en), .gain_flat(gain_flat), .offset_flat(offset_flat),
    .data_a_flat(data_a_flat), .data_b_flat(data_b_flat)
  );

  // Bench model of the bank
  logic [W-1:0] m_gain [NCH];
  logic [W-1:0] m_ofs  [NCH];
  logic [W-1:0] m_a    [NCH];
  logic [W-1:0] m_b    [NCH];
  logic         m_tog;

  // fld: 0 gain, 1 offset, 2 bank A, 3 bank B, 4 toggle, 5 whole-bank sweep
  typedef struct {
    string        req;
    int           ch;
    int           fld;
    logic [W-1:0] exp;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic logic [W-1:0] dut_field(int ch, int fld);
    case (fld)
      0: return gain_flat[ch*W +: W];
      1: return offset_flat[ch*W +: W];
      2: return data_a_flat[ch*W +: W];
      3: return data_b_flat[ch*W +: W];
      default: return {{(W-1){1'b0}}, toggle_en};
    endcase
  endfunction

  function automatic logic [W-1:0] mdl_field(int ch, int fld);
    case (fld)
      0: return m_gain[ch];
      1: return m_ofs[ch];
      2: return m_a[ch];
      3: return m_b[ch];
      default: return {{(W-1){1'b0}}, m_tog};
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_gain[c] = 14'h3FFF; m_ofs[c] = 14'h2000; m_a[c] = '0; m_b[c] = '0;
    end
    m_tog = 1'b0;
  endtask

  task automatic push(string req, int ch, int fld, logic [W-1:0] exp);
    item_t it;
    it.req = req; it.ch = ch; it.fld = fld; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic push_sweep(string req);
    push(req, 0, 5, '0);
  endtask

  // Monitor: pops expected items and compares with the design outputs.
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      n_checks++;
      if (it.fld == 5) begin
        bool_sweep(it.req);
      end else if (dut_field(it.ch, it.fld) !== it.exp) begin
        n_fail++;
        $display("FAIL %s ch %0d field %0d: actual %h expected %h",
                 it.req, it.ch, it.fld, dut_field(it.ch, it.fld), it.exp);
      end
    end
  end

  task automatic bool_sweep(string req);
    int bad = 0;
    for (int c = 0; c < NCH && bad == 0; c++) begin
      for (int f = 0; f < 5 && bad == 0; f++) begin
        if (dut_field(c, f) !== mdl_field(c, f)) begin
          bad = 1;
          n_fail++;
          $display("FAIL %s sweep ch %0d field %0d: actual %h expected %h",
                   req, c, f, dut_field(c, f), mdl_field(c, f));
        end
      end
    end
  endtask

  // Model update for one rising strobe edge, from the requirements.
  task automatic model_write(bit s_n, int a, int k, bit bb, logic [W-1:0] d);
    if (s_n) return;
    if (k == 0) begin
      if (a == 0) m_tog = d[0];
    end else if (a < NCH) begin
      if (k == 1)      m_gain[a] = d;
      else if (k == 2) m_ofs[a]  = d;
      else if (m_tog && bb) m_b[a] = d;
      else             m_a[a] = d;
    end
  endtask

  // Driver: one strobe pulse, model update, then the whole-bank sweep item.
  task automatic do_write(string req, bit s_n, int a, int k, bit bb, logic [W-1:0] d);
    @(negedge clk);
    wstb = 1'b0;
    @(negedge clk);
    sel_n = s_n; chan_addr = 6'(a); reg_kind = 2'(k); bank_b = bb; din = d;
    wstb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sel_n = 1'b1;
    model_write(s_n, a, k, bb, d);
    push_sweep(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    push("R1", 0, 0, 14'h3FFF);
    push("R1", 39, 1, 14'h2000);
    push("R1", 20, 2, 14'h0000);
    push("R1", 20, 3, 14'h0000);
    push("R1", 0, 4, 14'h0000);
    push_sweep("R1");

    // R6: gain and offset
    do_write("R6", 0, 5, 1, 0, 14'h1234);
    push("R6", 5, 0, 14'h1234);
    do_write("R6", 0, 39, 2, 0, 14'h0ABC);
    push("R6", 39, 1, 14'h0ABC);

    // R4: normal mode, bank_b ignored
    do_write("R4", 0, 7, 3, 1, 14'h2222);
    push("R4", 7, 2, 14'h2222);
    push("R4", 7, 3, 14'h0000);

    // R2: pulse with select high
    do_write("R2", 1, 8, 1, 0, 14'h0555);
    push("R2", 8, 0, 14'h3FFF);

    // R7: toggle enable set, other SF address ignored
    do_write("R7", 0, 0, 0, 0, 14'h0001);
    push("R7", 0, 4, 14'h0001);
    do_write("R7", 0, 3, 0, 0, 14'h0000);
    push("R7", 0, 4, 14'h0001);

    // R5: steered data writes
    do_write("R5", 0, 7, 3, 1, 14'h3FFF);
    push("R5", 7, 3, 14'h3FFF);
    push("R5", 7, 2, 14'h2222);
    do_write("R5", 0, 7, 3, 0, 14'h0001);
    push("R5", 7, 2, 14'h0001);

    // R8: out-of-range channels
    do_write("R8", 0, 40, 3, 0, 14'h1111);
    do_write("R8", 0, 63, 1, 0, 14'h0000);
    do_write("R8", 0, 41, 2, 0, 14'h0007);

    // R9: end channels
    do_write("R9", 0, 0, 3, 1, 14'h0F0F);
    push("R9", 0, 3, 14'h0F0F);
    do_write("R9", 0, 39, 1, 0, 14'h0001);
    push("R9", 39, 0, 14'h0001);

    // R3: strobe held high while other inputs change
    @(negedge clk);
    wstb = 1'b0;
    @(negedge clk);
    sel_n = 1'b0; chan_addr = 6'd12; reg_kind = 2'd1; bank_b = 1'b0; din = 14'h0123;
    wstb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_write(0, 12, 1, 0, 14'h0123);
    din = 14'h3210; chan_addr = 6'd13;
    repeat (2) @(negedge clk);
    reg_kind = 2'd2; din = 14'h0444;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    push("R3", 12, 0, 14'h0123);
    push("R3", 13, 0, 14'h3FFF);
    push_sweep("R3");

    // R4 again: toggle off, bank_b=1 goes to A
    do_write("R4", 0, 0, 0, 0, 14'h0000);
    push("R4", 0, 4, 14'h0000);
    do_write("R4", 0, 9, 3, 1, 14'h1357);
    push("R4", 9, 2, 14'h1357);
    push("R4", 9, 3, 14'h0000);

    // R1: reset in the middle of a run
    do_reset();
    @(negedge clk);
    push("R1", 5, 0, 14'h3FFF);
    push("R1", 7, 3, 14'h0000);
    push_sweep("R1");

    wait (q.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule